// File: doc/BRIEF.md
# Reference Clock Measurement Counter

This block gives host software a way to measure an unknown reference clock. It contains a 30-bit counter that steps down by one on each reference tick while counting is enabled. Software reads a start value, enables counting for a fixed interval, disables it, and reads the count again. The frequency follows from the difference between the two reads, and software does that arithmetic.

The host reaches the block through two identical register windows placed 8 bytes apart. Each window has an index port at byte offset 1 and a data port at byte offset 3. A byte written to an index port selects a register in that window. Reads and writes of the data port then go to the selected register. The counter value is split into four fields of 8, 7, 8 and 7 bits, spread over the two windows. Software reads the fields one at a time while the counter keeps running and retries if it sees a carry between reads, so the hardware never latches the count.

The reference tick is a single-cycle pulse synchronous to `clk_i`. It is produced outside this block, after any clock-domain crossing.

Top module: `clk_meas_counter`

## Requirements
- R1: After reset the counter holds INIT_COUNT (default all ones, 0x3FFFFFFF), the control register reads 0x00, and both index ports read 0x00.
- R2: A write to a window's index port (offset 1 primary, offset 9 secondary) stores the byte, and a read of that index port returns it.
- R3: The control register is at index 0x01 of the primary window (data port offset 3). It stores all 8 bits written to it and reads them back unchanged.
- R4: While control bit 6 is set, each cycle with `ref_tick_i` high lowers the counter by exactly one.
- R5: While control bit 6 is clear, the counter holds its value whatever `ref_tick_i` does. Setting the bit again resumes counting from the held value.
- R6: A tick at count zero loads 0x3FFFFFFF, with no other effect.
- R7: In the primary window, index 0x20 reads count bits 7:0 and index 0x21 reads count bits 14:8 in data bits 6:0, with data bit 7 reading zero.
- R8: In the secondary window (data port offset 11), index 0x20 reads count bits 22:15 and index 0x21 reads count bits 29:23 in data bits 6:0, with data bit 7 reading zero.
- R9: Reading a count field neither freezes nor latches the counter. A repeated read of the same field, with no new index write, returns the live value.
- R10: Data-port writes at count indices, at indices that map nothing, and at index 0x01 of the secondary window change nothing. Unmapped indices and unmapped byte offsets read 0x00.
- R11: The two index registers are independent. A write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| bus_addr_i | input | 4 | Byte offset within the two windows |
| bus_wr_i | input | 1 | Write strobe, one cycle per byte write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |

## Verification
The bench goes after the 7-bit fields, where a design that shifted the split by one bit or left bit 7 undriven would return wrong upper bytes once the count crosses bit 15. It drives a second instance, with a small initial count, through zero; a design that saturated or stopped at zero would then read 0 instead of 0x3FFFFFFF. A repeated read of the low byte across a tick catches a design that snapshots the count on index selection. Read-modify-write of the control register with unrelated bits set catches a design that stores only the enable bit. A write at secondary index 0x01 catches a decoder that ignores the window and so disables counting.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_FIELDS = 4;
  // field widths, low field first; the split is fixed by the host's readout
  localparam int FIELD_W [N_FIELDS] = '{8, 7, 8, 7};

  function automatic int field_lsb(int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += FIELD_W[i];
    return s;
  endfunction

  localparam int CNT_W = field_lsb(N_FIELDS);
  localparam int N_WIN = N_FIELDS / 2;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cmc_index_reg.sv
module cmc_index_reg
  import cmc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  byte_t wdata_i,
  output byte_t idx_o
);
  byte_t idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= '0;
    else if (wr_i) idx_q <= wdata_i;
  end

  assign idx_o = idx_q;

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(idx_q)); // R11
endmodule

// File: rtl/cmc_ctrl_reg.sv
module cmc_ctrl_reg
  import cmc_pkg::*;
#(
  parameter int EN_BIT = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  byte_t wdata_i,
  output byte_t ctrl_o,
  output logic  en_o
);
  byte_t ctrl_q;

  // all bits kept so host read-modify-write preserves them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = ctrl_q[EN_BIT];

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/cmc_down_counter.sv
module cmc_down_counter #(
  parameter int             W    = 30,
  parameter logic [W-1:0]   INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step = en_i & tick_i;

  // modulo 2^W: zero rolls to all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= INIT;
    else if (step) cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;

  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q != '0) |=> (cnt_q + W'(1) == $past(cnt_q))); // R4
  AST_WRAP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q == '0) |=> (cnt_q == '1)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && tick_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/cmc_rd_mux.sv
module cmc_rd_mux
  import cmc_pkg::*;
#(
  parameter int    ADDR_W     = 4,
  parameter int    WIN_STRIDE = 8,
  parameter int    IDX_OFS    = 1,
  parameter int    DAT_OFS    = 3,
  parameter byte_t CTRL_IDX   = 8'h01,
  parameter byte_t LO_IDX     = 8'h20,
  parameter byte_t HI_IDX     = 8'h21
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [N_WIN-1:0][BYTE_W-1:0]    idx_i,
  input  byte_t                           ctrl_i,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] field_i,
  output byte_t                           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (addr_i == ADDR_W'(w * WIN_STRIDE + IDX_OFS)) begin
        rdata_o = idx_i[w];
      end else if (addr_i == ADDR_W'(w * WIN_STRIDE + DAT_OFS)) begin
        if (idx_i[w] == LO_IDX)                 rdata_o = field_i[2*w];
        else if (idx_i[w] == HI_IDX)            rdata_o = field_i[2*w+1];
        else if (w == 0 && idx_i[w] == CTRL_IDX) rdata_o = ctrl_i;
      end
    end
  end
endmodule

// File: rtl/clk_meas_counter.sv
module clk_meas_counter
  import cmc_pkg::*;
#(
  parameter int               ADDR_W     = 4,
  parameter int               WIN_STRIDE = 8,
  parameter int               IDX_OFS    = 1,
  parameter int               DAT_OFS    = 3,
  parameter byte_t            CTRL_IDX   = 8'h01,
  parameter byte_t            LO_IDX     = 8'h20,
  parameter byte_t            HI_IDX     = 8'h21,
  parameter int               EN_BIT     = 6,
  parameter logic [CNT_W-1:0] INIT_COUNT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o
);
  localparam logic [ADDR_W-1:0] PRI_DAT = ADDR_W'(DAT_OFS);
  localparam logic [ADDR_W-1:0] SEC_DAT = ADDR_W'(WIN_STRIDE + DAT_OFS);

  logic [N_WIN-1:0][BYTE_W-1:0]    idx;
  logic [N_FIELDS-1:0][BYTE_W-1:0] field_b;
  logic [CNT_W-1:0]                cnt;
  byte_t                           ctrl;
  logic                            ctrl_wr;
  logic                            cnt_en;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    logic idx_wr;
    assign idx_wr = bus_wr_i && (bus_addr_i == ADDR_W'(w * WIN_STRIDE + IDX_OFS));
    cmc_index_reg u_idx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (idx_wr),
      .wdata_i (bus_wdata_i),
      .idx_o   (idx[w])
    );
  end

  // only the primary window carries the control register
  assign ctrl_wr = bus_wr_i && (bus_addr_i == PRI_DAT) && (idx[0] == CTRL_IDX);

  cmc_ctrl_reg #(.EN_BIT(EN_BIT)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl),
    .en_o    (cnt_en)
  );

  cmc_down_counter #(.W(CNT_W), .INIT(INIT_COUNT)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .tick_i (ref_tick_i),
    .cnt_o  (cnt)
  );

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_fld
    localparam int LSB = field_lsb(k);
    localparam int FW  = FIELD_W[k];
    assign field_b[k] = BYTE_W'(cnt[LSB +: FW]);
  end

  cmc_rd_mux #(
    .ADDR_W     (ADDR_W),
    .WIN_STRIDE (WIN_STRIDE),
    .IDX_OFS    (IDX_OFS),
    .DAT_OFS    (DAT_OFS),
    .CTRL_IDX   (CTRL_IDX),
    .LO_IDX     (LO_IDX),
    .HI_IDX     (HI_IDX)
  ) u_rd (
    .addr_i  (bus_addr_i),
    .idx_i   (idx),
    .ctrl_i  (ctrl),
    .field_i (field_b),
    .rdata_o (bus_rdata_o)
  );

  AST_SEC_NO_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == SEC_DAT) |=> $stable(ctrl)); // R10
  AST_PRI_HI_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == PRI_DAT && idx[0] == HI_IDX) |-> !bus_rdata_o[BYTE_W-1]); // R7
  AST_SEC_HI_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == SEC_DAT && idx[1] == HI_IDX) |-> !bus_rdata_o[BYTE_W-1]); // R8
endmodule

// File: tb/tb_clk_meas_counter.sv
module tb_clk_meas_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        tick_w = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, rdata_w;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [7:0]  ctrl_sh;
  logic [29:0] exp_cnt;

  always #10 clk = ~clk;

  clk_meas_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  clk_meas_counter #(.INIT_COUNT(30'd2)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick_w),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_w)
  );

  typedef struct packed {
    logic        en;
    logic [15:0] ticks;
    logic [29:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd1,     30'h3FFFFFFE},
    '{1'b1, 16'd255,   30'h3FFFFEFF},
    '{1'b0, 16'd10,    30'h3FFFFEFF},
    '{1'b1, 16'd256,   30'h3FFFFDFF},
    '{1'b0, 16'd3,     30'h3FFFFDFF},
    '{1'b1, 16'd32256, 30'h3FFF7FFF},
    '{1'b1, 16'd1,     30'h3FFF7FFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d, output logic [7:0] dw);
    @(negedge clk);
    addr = a;
    #2;
    d = rdata; dw = rdata_w;
  endtask

  task automatic run_ticks(input int n, input bit wrap_inst);
    @(negedge clk);
    if (n > 0) begin
      if (wrap_inst) tick_w = 1'b1; else tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0; tick_w = 1'b0;
    end
  endtask

  // reads the four fields of both instances
  task automatic read_fields(output logic [7:0] f [4], output logic [7:0] fw [4]);
    bus_write(4'd1, 8'h20); bus_read(4'd3, f[0], fw[0]);
    bus_write(4'd1, 8'h21); bus_read(4'd3, f[1], fw[1]);
    bus_write(4'd9, 8'h20); bus_read(4'd11, f[2], fw[2]);
    bus_write(4'd9, 8'h21); bus_read(4'd11, f[3], fw[3]);
  endtask

  task automatic chk_count(input string req, input logic [29:0] e, input bit wrap_inst);
    logic [7:0] f [4];
    logic [7:0] fw [4];
    logic [7:0] g [4];
    read_fields(f, fw);
    for (int i = 0; i < 4; i++) g[i] = wrap_inst ? fw[i] : f[i];
    chk({req, " R7 bits7:0"},   {24'h0, g[0]}, {24'h0, e[7:0]});
    chk({req, " R7 bits14:8"},  {24'h0, g[1]}, {25'h0, e[14:8]});
    chk({req, " R8 bits22:15"}, {24'h0, g[2]}, {24'h0, e[22:15]});
    chk({req, " R8 bits29:23"}, {24'h0, g[3]}, {25'h0, e[29:23]});
  endtask

  task automatic set_en(input logic en);
    logic [7:0] v, vw;
    bus_write(4'd1, 8'h01);
    bus_read(4'd3, v, vw);
    ctrl_sh = en ? (v | 8'h40) : (v & ~8'h40);
    bus_write(4'd3, ctrl_sh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, dw, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(4'd1, d, dw);  chk("R1 pri index", {24'h0, d}, 32'h0);
    bus_read(4'd9, d, dw);  chk("R1 sec index", {24'h0, d}, 32'h0);
    chk_count("R1 reset count", 30'h3FFFFFFF, 1'b0);
    chk_count("R1 init count wrap inst", 30'd2, 1'b1);
    bus_write(4'd1, 8'h01); bus_read(4'd3, d, dw);
    chk("R1 ctrl", {24'h0, d}, 32'h0);

    // R2 / R11 index ports
    bus_write(4'd1, 8'h5A);
    bus_write(4'd9, 8'hC3);
    bus_read(4'd1, d, dw);  chk("R2 R11 pri index", {24'h0, d}, 32'h5A);
    bus_read(4'd9, d, dw);  chk("R2 R11 sec index", {24'h0, d}, 32'hC3);

    // R3 full control byte
    bus_write(4'd1, 8'h01); bus_write(4'd3, 8'h15);
    bus_read(4'd3, d, dw);  chk("R3 ctrl readback", {24'h0, d}, 32'h15);
    ctrl_sh = 8'h15;

    // R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      set_en(VECS[i].en);
      bus_write(4'd1, 8'h01); bus_read(4'd3, d, dw);
      chk("R3 ctrl after rmw", {24'h0, d}, {24'h0, ctrl_sh});
      run_ticks(int'(VECS[i].ticks), 1'b0);
      chk_count(VECS[i].en ? "R4 vec" : "R5 vec", VECS[i].exp, 1'b0);
    end
    exp_cnt = 30'h3FFF7FFE;

    // R9 live reads, same index
    bus_write(4'd1, 8'h20);
    bus_read(4'd3, d, dw);
    run_ticks(1, 1'b0);
    bus_read(4'd3, d2, dw);
    exp_cnt = exp_cnt - 30'd1;
    chk("R9 first read", {24'h0, d}, 32'hFE);
    chk("R9 live reread", {24'h0, d2}, {24'h0, exp_cnt[7:0]});

    // R10 ignored writes
    bus_write(4'd1, 8'h20); bus_write(4'd3, 8'hAB);
    bus_write(4'd9, 8'h21); bus_write(4'd11, 8'h00);
    chk_count("R10 count writes ignored", exp_cnt, 1'b0);
    bus_write(4'd9, 8'h01); bus_write(4'd11, 8'h00);
    bus_read(4'd11, d, dw); chk("R10 sec idx1 reads zero", {24'h0, d}, 32'h0);
    bus_write(4'd1, 8'h01); bus_read(4'd3, d, dw);
    chk("R10 ctrl untouched", {24'h0, d}, {24'h0, ctrl_sh});
    run_ticks(1, 1'b0);
    exp_cnt = exp_cnt - 30'd1;
    chk_count("R10 still counting", exp_cnt, 1'b0);
    bus_write(4'd1, 8'h05); bus_write(4'd3, 8'h77);
    bus_read(4'd3, d, dw);  chk("R10 unmapped index", {24'h0, d}, 32'h0);
    bus_read(4'd0, d, dw);  chk("R10 offset 0", {24'h0, d}, 32'h0);
    bus_read(4'd2, d, dw);  chk("R10 offset 2", {24'h0, d}, 32'h0);
    bus_read(4'd15, d, dw); chk("R10 offset 15", {24'h0, d}, 32'h0);

    // R6 wrap through zero
    run_ticks(2, 1'b1);
    chk_count("R6 at zero", 30'd0, 1'b1);
    run_ticks(1, 1'b1);
    chk_count("R6 wrapped", 30'h3FFFFFFF, 1'b1);
    run_ticks(1, 1'b1);
    chk_count("R6 after wrap", 30'h3FFFFFFE, 1'b1);

    // R5 hold and resume
    set_en(1'b0);
    run_ticks(4, 1'b0);
    chk_count("R5 held", exp_cnt, 1'b0);
    set_en(1'b1);
    run_ticks(2, 1'b0);
    exp_cnt = exp_cnt - 30'd2;
    chk_count("R5 resumed", exp_cnt, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule